// File: doc/BRIEF.md
# Security Interrupt Status Aggregator

This block is the secure-side collection point for interrupt status coming from the peripheral protection controllers, the memory protection controllers and the bus-master security controllers of a subsystem. Each source reports a level. The block latches or mirrors that level into a 32-bit status word at a fixed bit position. Software reads the status words through a word-wide register port and clears or enables individual sources there.

The block feeds its decisions back to the sources. Each protection controller gets an enable line and a clear line. Each master security controller gets a clear pulse. A combined master-security interrupt is raised whenever an enabled status bit is set. Two configuration outputs are also held here: a 1-bit security response configuration and a 2-bit non-secure-callable configuration. The bus-bridge error interrupt never becomes pending, so its status always reads as zero.

Top module: `sec_irq_agg`

## Requirements
- R1: A high level on protection controller input c sets its status bit (readable at offset 0x20) one cycle later. Inputs are ordered internal APB 0..1, then APB expansion 0..3, then AHB expansion 0..3. These map to status bits 0..1, 4..7 and 20..23. The bit stays set after the input falls.
- R2: A full-word write to offset 0x24 clears every status bit written as 1, limited to mask 0x00F000F3. An input that is high in the same cycle as the write keeps its bit set.
- R3: A full-word write to offset 0x28 stores the data ANDed with 0x00F000F3, and that value reads back at 0x28. Each protection controller's enable output (`ppc_en[c]`) equals the stored bit at its own position.
- R4: Each protection controller's clear output (`ppc_clr[c]`) equals its own status bit.
- R5: The memory-protection status at 0x1C shows internal input n at bit n and expansion input n at bit 16+n, one cycle after the inputs.
- R6: The master-security status at 0x30 shows expansion input n at bit 16+n, one cycle after the input. The enable register at 0x38 stores all 32 bits. `msc_irq` is high when status AND enable is nonzero.
- R7: A full-word write to 0x34 drives `msc_clr[i]` from written bit 16+i for exactly one cycle after the write. Reading 0x34 returns zero.
- R8: A write to 0x10 keeps bit 0 as `resp_cfg`. A write to 0x14 keeps bits [1:0] as `nsc_cfg`. Both read back at their offsets.
- R9: The bridge status at 0x40 and the bridge clear at 0x44 always read zero. The bridge enable at 0x48 keeps only bits [31:16].
- R10: Writes to the status offsets (0x1C, 0x20, 0x30, 0x40) change nothing. A write whose byte enables are not all four set (`reg_be` != 4'hF) changes nothing.
- R11: After the synchronous reset, every status, enable and configuration register reads zero, and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte offset of the access |
| reg_be | input | 4 | Byte enables; only 4'hF writes take effect |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ppc_irq | input | N_APB+N_APBX+N_AHBX | Protection controller interrupt levels |
| mpc_irq | input | N_MPC | Internal memory-protection interrupt levels |
| mpcx_irq | input | N_MPCX | Expansion memory-protection interrupt levels |
| mscx_irq | input | N_MSCX | Expansion master-security interrupt levels |
| ppc_en | output | N_APB+N_APBX+N_AHBX | Per-controller interrupt enable |
| ppc_clr | output | N_APB+N_APBX+N_AHBX | Per-controller interrupt clear |
| msc_clr | output | N_MSCX | One-cycle clear pulse per master security controller |
| msc_irq | output | 1 | Combined master-security interrupt |
| resp_cfg | output | 1 | Security response configuration |
| nsc_cfg | output | 2 | Non-secure-callable configuration |

## Verification
Two functions can meet in one cycle: a protection controller raising its level, and software clearing that same status bit. The bench lines them up by driving the input high on the same falling edge that presents a clear write for that bit. It then reads back that the bit survived and that the controller's clear line is still high. After the input is dropped, a second clear must succeed, which shows that the earlier survival came from the live input and not from a clear that failed to act.

// File: rtl/secagg_pkg.sv
package secagg_pkg;

    localparam int AW = 12;
    localparam int DW = 32;

    localparam logic [AW-1:0] OFS_RESP    = 12'h010;
    localparam logic [AW-1:0] OFS_NSC     = 12'h014;
    localparam logic [AW-1:0] OFS_MPC_ST  = 12'h01C;
    localparam logic [AW-1:0] OFS_PPC_ST  = 12'h020;
    localparam logic [AW-1:0] OFS_PPC_CLR = 12'h024;
    localparam logic [AW-1:0] OFS_PPC_EN  = 12'h028;
    localparam logic [AW-1:0] OFS_MSC_ST  = 12'h030;
    localparam logic [AW-1:0] OFS_MSC_CLR = 12'h034;
    localparam logic [AW-1:0] OFS_MSC_EN  = 12'h038;
    localparam logic [AW-1:0] OFS_BRG_ST  = 12'h040;
    localparam logic [AW-1:0] OFS_BRG_CLR = 12'h044;
    localparam logic [AW-1:0] OFS_BRG_EN  = 12'h048;

    localparam int APBX_BASE = 4;
    localparam int AHBX_BASE = 20;
    localparam int XP_BASE   = 16;

    // Full-word write strobes, one per writable register
    typedef struct packed {
        logic resp;
        logic nsc;
        logic ppc_clr;
        logic ppc_en;
        logic msc_clr;
        logic msc_en;
        logic brg_en;
    } wstb_t;

    typedef struct packed {
        logic        resp;
        logic [1:0]  nsc;
        logic [15:0] brg_en;
    } cfg_t;

    // Status bit position of protection controller c
    function automatic int ctl_bit(input int c, input int n_apb, input int n_apbx);
        if (c < n_apb)               return c;
        else if (c < n_apb + n_apbx) return APBX_BASE + (c - n_apb);
        else                         return AHBX_BASE + (c - n_apb - n_apbx);
    endfunction

    function automatic logic [DW-1:0] ppc_mask(input int n_apb, input int n_apbx, input int n_ahbx);
        logic [DW-1:0] m;
        m = '0;
        for (int c = 0; c < n_apb + n_apbx + n_ahbx; c++) m[ctl_bit(c, n_apb, n_apbx)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/secagg_decode.sv
module secagg_decode
    import secagg_pkg::*;
(
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [3:0]    reg_be,
    output wstb_t         wstb
);
    logic full;
    assign full = reg_wr && (reg_be == 4'hF);

    always_comb begin
        wstb         = '0;
        wstb.resp    = full && (reg_addr == OFS_RESP);
        wstb.nsc     = full && (reg_addr == OFS_NSC);
        wstb.ppc_clr = full && (reg_addr == OFS_PPC_CLR);
        wstb.ppc_en  = full && (reg_addr == OFS_PPC_EN);
        wstb.msc_clr = full && (reg_addr == OFS_MSC_CLR);
        wstb.msc_en  = full && (reg_addr == OFS_MSC_EN);
        wstb.brg_en  = full && (reg_addr == OFS_BRG_EN);
    end
endmodule

// File: rtl/secagg_ppc_bank.sv
module secagg_ppc_bank
    import secagg_pkg::*;
#(
    parameter int N_APB  = 2,
    parameter int N_APBX = 4,
    parameter int N_AHBX = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [N_APB+N_APBX+N_AHBX-1:0]  irq_in,
    input  logic                            clr_stb,
    input  logic                            en_stb,
    input  logic [DW-1:0]                   wdata,
    output logic [DW-1:0]                   stat,
    output logic [DW-1:0]                   en,
    output logic [N_APB+N_APBX+N_AHBX-1:0]  ctl_en,
    output logic [N_APB+N_APBX+N_AHBX-1:0]  ctl_clr
);
    localparam int N_CTL = N_APB + N_APBX + N_AHBX;
    localparam logic [DW-1:0] MASK = ppc_mask(N_APB, N_APBX, N_AHBX);

    logic [DW-1:0] in_vec;
    logic [DW-1:0] clr_vec;

    always_comb begin
        in_vec = '0;
        for (int c = 0; c < N_CTL; c++) in_vec[ctl_bit(c, N_APB, N_APBX)] = irq_in[c];
    end

    assign clr_vec = clr_stb ? (wdata & MASK) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            en   <= '0;
        end else begin
            stat <= (stat & ~clr_vec) | in_vec;
            if (en_stb) en <= wdata & MASK;
        end
    end

    for (genvar c = 0; c < N_CTL; c++) begin : g_ctl
        localparam int B = ctl_bit(c, N_APB, N_APBX);
        assign ctl_en[c]  = en[B];
        assign ctl_clr[c] = stat[B];
    end

    assert_set_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((stat & $past(in_vec)) == $past(in_vec)));
    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((stat & $past(clr_vec & ~in_vec)) == '0));
    assert_enable_R3: assert property (@(posedge clk) disable iff (rst)
        en_stb |=> (en == ($past(wdata) & MASK)));
endmodule

// File: rtl/secagg_level_cap.sv
module secagg_level_cap
    import secagg_pkg::*;
#(
    parameter int W_LO = 1,
    parameter int W_HI = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [W_LO-1:0] lo_in,
    input  logic [W_HI-1:0] hi_in,
    output logic [DW-1:0]   stat
);
    logic [DW-1:0] placed;

    always_comb begin
        placed = '0;
        placed[W_LO-1:0] = lo_in;
        placed[XP_BASE +: W_HI] = hi_in;
    end

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= placed;
    end

    // R5 and R6: status mirrors the inputs one cycle late
    assert_level_follow_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (stat == $past(placed)));
endmodule

// File: rtl/sec_irq_agg.sv
module sec_irq_agg
    import secagg_pkg::*;
#(
    parameter int N_APB  = 2,
    parameter int N_APBX = 4,
    parameter int N_AHBX = 4,
    parameter int N_MPC  = 2,
    parameter int N_MPCX = 4,
    parameter int N_MSCX = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           reg_wr,
    input  logic [11:0]                    reg_addr,
    input  logic [3:0]                     reg_be,
    input  logic [31:0]                    reg_wdata,
    output logic [31:0]                    reg_rdata,
    input  logic [N_APB+N_APBX+N_AHBX-1:0] ppc_irq,
    input  logic [N_MPC-1:0]               mpc_irq,
    input  logic [N_MPCX-1:0]              mpcx_irq,
    input  logic [N_MSCX-1:0]              mscx_irq,
    output logic [N_APB+N_APBX+N_AHBX-1:0] ppc_en,
    output logic [N_APB+N_APBX+N_AHBX-1:0] ppc_clr,
    output logic [N_MSCX-1:0]              msc_clr,
    output logic                           msc_irq,
    output logic                           resp_cfg,
    output logic [1:0]                     nsc_cfg
);
    wstb_t         wstb;
    cfg_t          cfg;
    logic [DW-1:0] ppc_stat, ppc_en_q, mpc_stat, msc_stat, msc_en_q;

    secagg_decode u_dec (
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be), .wstb(wstb)
    );

    secagg_ppc_bank #(.N_APB(N_APB), .N_APBX(N_APBX), .N_AHBX(N_AHBX)) u_ppc (
        .clk(clk), .rst(rst), .irq_in(ppc_irq),
        .clr_stb(wstb.ppc_clr), .en_stb(wstb.ppc_en), .wdata(reg_wdata),
        .stat(ppc_stat), .en(ppc_en_q), .ctl_en(ppc_en), .ctl_clr(ppc_clr)
    );

    secagg_level_cap #(.W_LO(N_MPC), .W_HI(N_MPCX)) u_mpc (
        .clk(clk), .rst(rst), .lo_in(mpc_irq), .hi_in(mpcx_irq), .stat(mpc_stat)
    );

    secagg_level_cap #(.W_LO(1), .W_HI(N_MSCX)) u_msc (
        .clk(clk), .rst(rst), .lo_in(1'b0), .hi_in(mscx_irq), .stat(msc_stat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            msc_en_q <= '0;
            msc_clr  <= '0;
        end else begin
            if (wstb.resp)   cfg.resp   <= reg_wdata[0];
            if (wstb.nsc)    cfg.nsc    <= reg_wdata[1:0];
            if (wstb.brg_en) cfg.brg_en <= reg_wdata[31:16];
            if (wstb.msc_en) msc_en_q   <= reg_wdata;
            msc_clr <= wstb.msc_clr ? reg_wdata[XP_BASE +: N_MSCX] : '0;
        end
    end

    assign msc_irq  = |(msc_stat & msc_en_q);
    assign resp_cfg = cfg.resp;
    assign nsc_cfg  = cfg.nsc;

    always_comb begin
        case (reg_addr)
            OFS_RESP:   reg_rdata = {31'h0, cfg.resp};
            OFS_NSC:    reg_rdata = {30'h0, cfg.nsc};
            OFS_MPC_ST: reg_rdata = mpc_stat;
            OFS_PPC_ST: reg_rdata = ppc_stat;
            OFS_PPC_EN: reg_rdata = ppc_en_q;
            OFS_MSC_ST: reg_rdata = msc_stat;
            OFS_MSC_EN: reg_rdata = msc_en_q;
            OFS_BRG_EN: reg_rdata = {cfg.brg_en, 16'h0};
            default:    reg_rdata = '0;
        endcase
    end

    assert_cfg_nsc_R8: assert property (@(posedge clk) disable iff (rst)
        wstb.nsc |=> (nsc_cfg == $past(reg_wdata[1:0])));
    assert_msc_clr_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (msc_clr == ($past(wstb.msc_clr) ? $past(reg_wdata[XP_BASE +: N_MSCX]) : '0)));
    assert_subword_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_be != 4'hF) |=> ($stable(cfg) && $stable(msc_en_q) && $stable(ppc_en_q)));
    assert_msc_irq_R6: assert property (@(posedge clk) disable iff (rst)
        msc_irq |-> (msc_stat != '0 && msc_en_q != '0));
    assert_bridge_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_BRG_ST) |-> (reg_rdata == '0));
endmodule

// File: tb/sec_irq_agg_tb.sv
`timescale 1ns/1ps
module sec_irq_agg_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [3:0]  reg_be = 4'hF;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [9:0]  ppc_irq = '0;
    logic [1:0]  mpc_irq = '0;
    logic [3:0]  mpcx_irq = '0;
    logic [3:0]  mscx_irq = '0;
    logic [9:0]  ppc_en, ppc_clr;
    logic [3:0]  msc_clr;
    logic        msc_irq, resp_cfg;
    logic [1:0]  nsc_cfg;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sec_irq_agg dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ppc_irq(ppc_irq),
        .mpc_irq(mpc_irq), .mpcx_irq(mpcx_irq), .mscx_irq(mscx_irq),
        .ppc_en(ppc_en), .ppc_clr(ppc_clr), .msc_clr(msc_clr), .msc_irq(msc_irq),
        .resp_cfg(resp_cfg), .nsc_cfg(nsc_cfg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_be = 4'hF;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tick();
        @(negedge clk); @(posedge clk); #1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(12'h028, v); check("R11 ppc enable", v, 0);
        rd(12'h020, v); check("R11 ppc status", v, 0);
        rd(12'h038, v); check("R11 msc enable", v, 0);
        check("R11 outputs", {ppc_en, ppc_clr, msc_clr, msc_irq, resp_cfg, nsc_cfg}, 0);
    endtask

    task automatic t_ppc_set_clear();
        logic [31:0] v;
        @(negedge clk); ppc_irq = 10'b01_0000_1001; // idx 0, 3, 8
        @(posedge clk); #1;
        @(negedge clk); ppc_irq = '0;
        tick();
        rd(12'h020, v); check("R1 sticky status map", v, 32'h0040_0021);
        check("R4 clear outputs", {22'h0, ppc_clr}, 32'h109);
        wr(12'h024, 32'h0000_0021);
        rd(12'h020, v); check("R2 partial clear", v, 32'h0040_0000);
        check("R4 clear outputs after clear", {22'h0, ppc_clr}, 32'h100);
        wr(12'h024, 32'hFFFF_FFFF);
        rd(12'h020, v); check("R2 full clear", v, 0);
    endtask

    task automatic t_ppc_collide();
        logic [31:0] v;
        @(negedge clk);
        ppc_irq = 10'b00_0000_0010; // idx 1 -> bit 1
        reg_wr = 1'b1; reg_addr = 12'h024; reg_wdata = 32'h2; reg_be = 4'hF;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        rd(12'h020, v); check("R2 clear vs live input", v, 32'h2);
        check("R4 clear line stays", {22'h0, ppc_clr}, 32'h2);
        @(negedge clk); ppc_irq = '0;
        wr(12'h024, 32'h2);
        rd(12'h020, v); check("R2 clear after drop", v, 0);
    endtask

    task automatic t_ppc_enable();
        logic [31:0] v;
        wr(12'h028, 32'hFFFF_FFFF);
        rd(12'h028, v); check("R3 enable masked", v, 32'h00F0_00F3);
        check("R3 all enables", {22'h0, ppc_en}, 32'h3FF);
        wr(12'h028, 32'h0020_0010);
        check("R3 enable map", {22'h0, ppc_en}, 32'h084);
    endtask

    task automatic t_mpc();
        logic [31:0] v;
        @(negedge clk); mpc_irq = 2'b10; mpcx_irq = 4'b0101;
        @(posedge clk); #1;
        rd(12'h01C, v); check("R5 mpc status", v, 32'h0005_0002);
        @(negedge clk); mpc_irq = '0; mpcx_irq = '0;
        @(posedge clk); #1;
        rd(12'h01C, v); check("R5 mpc follows low", v, 0);
    endtask

    task automatic t_msc();
        logic [31:0] v;
        @(negedge clk); mscx_irq = 4'b1001;
        @(posedge clk); #1;
        rd(12'h030, v); check("R6 msc status", v, 32'h0009_0000);
        check("R6 irq disabled", {31'h0, msc_irq}, 0);
        wr(12'h038, 32'h0008_0000);
        check("R6 irq enabled", {31'h0, msc_irq}, 1);
        wr(12'h038, 32'h0006_0000);
        check("R6 irq other bits", {31'h0, msc_irq}, 0);
        rd(12'h038, v); check("R6 enable readback", v, 32'h0006_0000);
        @(negedge clk); mscx_irq = '0;
    endtask

    task automatic t_msc_clear();
        logic [31:0] v;
        wr(12'h034, 32'h000A_0001);
        check("R7 clear pulse", {28'h0, msc_clr}, 32'hA);
        tick();
        check("R7 pulse ends", {28'h0, msc_clr}, 0);
        rd(12'h034, v); check("R7 clear reads zero", v, 0);
    endtask

    task automatic t_cfg();
        logic [31:0] v;
        wr(12'h014, 32'hFFFF_FFFD);
        check("R8 nsc output", {30'h0, nsc_cfg}, 1);
        rd(12'h014, v); check("R8 nsc readback", v, 1);
        wr(12'h010, 32'h0000_0005);
        check("R8 resp output", {31'h0, resp_cfg}, 1);
        rd(12'h010, v); check("R8 resp readback", v, 1);
    endtask

    task automatic t_bridge();
        logic [31:0] v;
        wr(12'h048, 32'h1234_5678);
        rd(12'h048, v); check("R9 bridge enable upper", v, 32'h1234_0000);
        rd(12'h040, v); check("R9 bridge status zero", v, 0);
        wr(12'h044, 32'hFFFF_FFFF);
        rd(12'h044, v); check("R9 bridge clear reads zero", v, 0);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        wr(12'h020, 32'hFFFF_FFFF);
        rd(12'h020, v); check("R10 ppc status write", v, 0);
        wr(12'h01C, 32'hFFFF_FFFF);
        rd(12'h01C, v); check("R10 mpc status write", v, 0);
        wr(12'h030, 32'hFFFF_FFFF);
        rd(12'h030, v); check("R10 msc status write", v, 0);
        wr(12'h014, 32'h3, 4'h3);
        check("R10 subword nsc", {30'h0, nsc_cfg}, 1);
        wr(12'h028, 32'hFFFF_FFFF, 4'hE);
        rd(12'h028, v); check("R10 subword enable", v, 32'h0020_0010);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_ppc_set_clear();
        t_ppc_collide();
        t_ppc_enable();
        t_mpc();
        t_msc();
        t_msc_clear();
        t_cfg();
        t_bridge();
        t_ignored();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule